// File: doc/BRIEF.md
# Receive FIFO with End-of-Message Aware Ready Flag

This block sits between a serial receiver and whatever drains received bytes, whether a host processor or a DMA engine. It holds up to 32 bytes in arrival order. Each byte carries a one-bit end-of-message tag, and the tag comes back with the byte when it is read. An occupancy counter tracks how many bytes are held. A byte that arrives while the buffer is full is discarded, and a sticky overrun bit records the loss.

The block raises a ready flag that tells the consumer to start draining. The flag comes up when the occupancy exceeds a programmable 5-bit threshold. When the mode input selects bit-synchronous operation, an accepted byte tagged end-of-message also raises the flag, whatever the count. Once raised, the flag stays up until the buffer has been read completely empty. This hysteresis lets a consumer drain a whole burst without the flag dropping partway through. The flag drives a DMA request directly. It also drives an interrupt request that is gated by an enable input.

Reads are synchronous, so a read accepted at one clock edge presents its byte on that same edge. The storage array is written so that an FPGA block RAM can hold it.

Top module: `rx_ready_fifo`

## Requirements
- R1: While `rst` is high and after it falls, `level`, `rx_ready`, `irq`, `dma_req`, `overrun`, `rd_data` and `rd_eom` are all 0.
- R2: Bytes and their end-of-message tags are read out in the order they were written. The clock edge that accepts a read updates `rd_data`/`rd_eom` with that byte.
- R3: `level` rises by one for each accepted write and falls by one for each accepted read. A write while `level` is 32 is dropped and leaves the contents unchanged. A read while `level` is 0 is ignored, and `level` and `rd_data` keep their values.
- R4: `rx_ready` is 1 in any cycle whose `level` is greater than the `thresh` value sampled at the preceding edge, where `thresh` is 5 bits (0 to 31). This holds in every mode.
- R5: When `mode` is 2'b10 (bit-synchronous), an accepted write with `wr_eom`=1 sets `rx_ready` at that edge, even below the threshold. With `mode` 2'b00 (asynchronous) or 2'b01 (byte-synchronous), `wr_eom` has no effect on `rx_ready`.
- R6: Once set, `rx_ready` stays 1 while `level` is non-zero, even below the threshold. It is 0 whenever `level` is 0.
- R7: At each edge, `irq` is loaded with the new `rx_ready` value ANDed with `irq_en`.
- R8: `dma_req` is always equal to `rx_ready`.
- R9: A write attempt while `level` is 32 sets `overrun`. `overrun` stays set until a cycle with `ovr_clr`=1. When a new overrun and `ovr_clr` happen in the same cycle, `overrun` stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 asynchronous, 01 byte-synchronous, 10 bit-synchronous |
| thresh | input | 5 | Ready threshold; the flag is raised when the level exceeds it |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_data | input | 8 | Byte to store |
| wr_eom | input | 1 | End-of-message tag of the byte being written |
| rd_en | input | 1 | Read strobe from the consumer |
| ovr_clr | input | 1 | Clears the overrun bit |
| rd_data | output | 8 | Byte delivered by the last accepted read |
| rd_eom | output | 1 | Tag of the byte delivered by the last accepted read |
| level | output | 6 | Number of bytes held (0 to 32) |
| rx_ready | output | 1 | Ready flag with hysteresis |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| overrun | output | 1 | Sticky overrun indication |

## Verification
The bench sweeps all 32 threshold values in all three modes. It fills the buffer one byte at a time and checks the flag after every write. A design that compared against the threshold with an off-by-one error, or that took its count one cycle late, would flag at the wrong byte. It then drains to empty and checks that the flag holds below the threshold and drops only on the last read. A design that cleared the flag on the threshold instead would drop it early. Directed cases cover these points:
- An end-of-message byte under the maximum threshold, in each mode, which catches a trigger that ignores the mode.
- A write to a full buffer, which catches an overwritten byte or an over-counted level.
- A read of an empty buffer.
- Overrun set and clear arriving in the same cycle.
- Enable gating of the interrupt.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_BYTE  = 2'b01,
    MODE_BIT   = 2'b10
  } rx_mode_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eom,
  input  logic              rd_ok,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_eom
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W:0]   mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [DATA_W:0]   out_q;

  // Array without reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= {wr_eom, wr_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else if (rd_ok) begin
      out_q <= mem[rptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
    end
  end

  assign rd_data = out_q[DATA_W-1:0];
  assign rd_eom  = out_q[DATA_W];
endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic                         ovr_clr,
  output logic                         wr_ok,
  output logic                         rd_ok,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_next,
  output logic                         overrun
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic full, empty;

  assign full  = (cnt == FULL_CNT);
  assign empty = (cnt == '0);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  always_comb begin
    case ({wr_ok, rd_ok})
      2'b10:   cnt_next = cnt + 1'b1;
      2'b01:   cnt_next = cnt - 1'b1;
      default: cnt_next = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      overrun <= 1'b0;
    end else begin
      cnt <= cnt_next;
      if (wr_en && full)  overrun <= 1'b1;
      else if (ovr_clr)   overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/rxf_ready.sv
module rxf_ready
  import rxf_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  mode,
  input  logic [$clog2(DEPTH)-1:0]    thresh,
  input  logic                        irq_en,
  input  logic [$clog2(DEPTH+1)-1:0]  cnt_next,
  input  logic                        eom_in,
  output logic                        rx_ready,
  output logic                        irq,
  output logic                        dma_req
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic set_lvl, set_eom, ready_n;

  assign set_lvl = cnt_next > CNT_W'(thresh);
  assign set_eom = eom_in && (mode == MODE_BIT);
  // Hysteresis: once up, only an empty buffer drops the flag.
  assign ready_n = set_lvl || set_eom || (rx_ready && (cnt_next != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ready <= 1'b0;
      irq      <= 1'b0;
      dma_req  <= 1'b0;
    end else begin
      rx_ready <= ready_n;
      irq      <= ready_n && irq_en;
      dma_req  <= ready_n;
    end
  end
endmodule

// File: rtl/rx_ready_fifo.sv
module rx_ready_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  mode,
  input  logic [$clog2(DEPTH)-1:0]    thresh,
  input  logic                        irq_en,
  input  logic                        wr_en,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        wr_eom,
  input  logic                        rd_en,
  input  logic                        ovr_clr,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        rd_eom,
  output logic [$clog2(DEPTH+1)-1:0]  level,
  output logic                        rx_ready,
  output logic                        irq,
  output logic                        dma_req,
  output logic                        overrun
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             wr_ok, rd_ok;
  logic [CNT_W-1:0] cnt_next;

  rxf_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .ovr_clr(ovr_clr),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .cnt(level), .cnt_next(cnt_next),
    .overrun(overrun)
  );

  rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .wr_data(wr_data), .wr_eom(wr_eom),
    .rd_ok(rd_ok), .rd_data(rd_data), .rd_eom(rd_eom)
  );

  rxf_ready #(.DEPTH(DEPTH)) u_ready (
    .clk(clk), .rst(rst), .mode(mode), .thresh(thresh), .irq_en(irq_en),
    .cnt_next(cnt_next), .eom_in(wr_ok && wr_eom),
    .rx_ready(rx_ready), .irq(irq), .dma_req(dma_req)
  );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DEPTH = 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic [1:0]                  mode,
  input logic [$clog2(DEPTH)-1:0]    thresh,
  input logic                        irq_en,
  input logic                        wr_en,
  input logic                        wr_eom,
  input logic                        rd_en,
  input logic [$clog2(DEPTH+1)-1:0]  level,
  input logic                        rx_ready,
  input logic                        irq,
  input logic                        dma_req,
  input logic                        overrun
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  p_level_cap_r3: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_CNT);

  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (level == FULL_CNT && wr_en && !rd_en) |=> level == FULL_CNT);

  p_thresh_set_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && level > CNT_W'($past(thresh))) |-> rx_ready);

  p_eom_set_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && wr_eom && mode == 2'b10 && level != FULL_CNT))
      |-> rx_ready);

  p_empty_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |-> !rx_ready);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rx_ready) && level != '0) |-> rx_ready);

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == (rx_ready && $past(irq_en))));

  p_dma_match_r8: assert property (@(posedge clk) disable iff (rst)
    dma_req == rx_ready);

  p_ovr_set_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && level == FULL_CNT)) |-> overrun);

  p_unused_rd: assert property (@(posedge clk) disable iff (rst)
    (rd_en && level == '0 && !wr_en) |=> level == '0);
endmodule

bind rx_ready_fifo rxf_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_rx_ready_fifo.sv
module test_rx_ready_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 32;

  logic       clk, rst;
  logic [1:0] mode;
  logic [4:0] thresh;
  logic       irq_en, wr_en, wr_eom, rd_en, ovr_clr;
  logic [7:0] wr_data, rd_data;
  logic       rd_eom, rx_ready, irq, dma_req, overrun;
  logic [5:0] level;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  rx_ready_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rx_ready_fifo (
    .clk(clk), .rst(rst), .mode(mode), .thresh(thresh), .irq_en(irq_en),
    .wr_en(wr_en), .wr_data(wr_data), .wr_eom(wr_eom), .rd_en(rd_en),
    .ovr_clr(ovr_clr), .rd_data(rd_data), .rd_eom(rd_eom), .level(level),
    .rx_ready(rx_ready), .irq(irq), .dma_req(dma_req), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_eom = 1'b0; ovr_clr = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d, input logic e);
    wr_en = 1'b1; wr_data = d; wr_eom = e;
    step();
    wr_en = 1'b0; wr_eom = 1'b0;
  endtask

  task automatic rd();
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] pat(int m, int t, int k);
    return 8'((t * 7 + k * 13 + m * 5) & 255);
  endfunction

  initial begin
    rst = 1'b1; mode = 2'b00; thresh = 5'd0; irq_en = 1'b0;
    wr_en = 1'b0; wr_data = 8'h00; wr_eom = 1'b0; rd_en = 1'b0; ovr_clr = 1'b0;
    do_reset();
    chk("R1 level", int'(level), 0);
    chk("R1 rx_ready", int'(rx_ready), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 dma_req", int'(dma_req), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 rd_eom", int'(rd_eom), 0);

    // R3: read of an empty buffer is ignored
    rd();
    chk("R3 empty read level", int'(level), 0);
    chk("R3 empty read data", int'(rd_data), 0);
    chk("R6 empty ready", int'(rx_ready), 0);

    // Sweep: every mode, every threshold, fill then drain
    for (int m = 0; m < 3; m++) begin
      for (int t = 0; t < 32; t++) begin
        do_reset();
        mode = 2'(m); thresh = 5'(t);
        for (int k = 1; k <= DEPTH; k++) begin
          wr(pat(m, t, k), 1'b0);
          chk("R3 fill level", int'(level), k);
          chk("R4 threshold", int'(rx_ready), (k > t) ? 1 : 0);
          chk("R8 dma", int'(dma_req), int'(rx_ready));
        end
        for (int k = 1; k <= DEPTH; k++) begin
          rd();
          chk("R2 order", int'(rd_data), int'(pat(m, t, k)));
          chk("R6 hold/clear", int'(rx_ready), (k < DEPTH) ? 1 : 0);
          chk("R3 drain level", int'(level), DEPTH - k);
        end
      end
    end

    // R5: end-of-message trigger only in bit-synchronous mode
    for (int m = 0; m < 3; m++) begin
      do_reset();
      mode = 2'(m); thresh = 5'd31;
      wr(8'h11, 1'b0);
      wr(8'h22, 1'b0);
      chk("R4 below threshold", int'(rx_ready), 0);
      wr(8'h33, 1'b1);
      chk("R5 eom trigger", int'(rx_ready), (m == 2) ? 1 : 0);
      rd();
      chk("R2 eom tag clear", int'(rd_eom), 0);
      chk("R6 hold after eom", int'(rx_ready), (m == 2) ? 1 : 0);
      rd();
      chk("R6 hold after eom", int'(rx_ready), (m == 2) ? 1 : 0);
      rd();
      chk("R2 eom tag set", int'(rd_eom), 1);
      chk("R2 eom data", int'(rd_data), 8'h33);
      chk("R6 cleared at empty", int'(rx_ready), 0);
    end

    // R9: overrun on full
    do_reset();
    mode = 2'b00; thresh = 5'd31;
    for (int k = 1; k <= DEPTH; k++) wr(pat(7, 0, k), 1'b0);
    chk("R9 no overrun at full", int'(overrun), 0);
    wr(8'hEE, 1'b1);
    chk("R3 full drop level", int'(level), DEPTH);
    chk("R9 overrun set", int'(overrun), 1);
    for (int k = 1; k <= DEPTH; k++) begin
      rd();
      chk("R3 full drop data", int'(rd_data), int'(pat(7, 0, k)));
    end
    chk("R9 overrun sticky", int'(overrun), 1);
    ovr_clr = 1'b1; step(); ovr_clr = 1'b0;
    chk("R9 overrun cleared", int'(overrun), 0);
    for (int k = 1; k <= DEPTH; k++) wr(8'(k), 1'b0);
    wr_en = 1'b1; ovr_clr = 1'b1; step(); wr_en = 1'b0; ovr_clr = 1'b0;
    chk("R9 set beats clear", int'(overrun), 1);

    // R7: interrupt gating
    do_reset();
    mode = 2'b00; thresh = 5'd0; irq_en = 1'b1;
    step();
    chk("R7 irq idle", int'(irq), 0);
    irq_en = 1'b0;
    wr(8'h5A, 1'b0);
    chk("R7 irq masked", int'(irq), 0);
    chk("R4 ready at one", int'(rx_ready), 1);
    irq_en = 1'b1; step();
    chk("R7 irq enabled", int'(irq), 1);
    irq_en = 1'b0; step();
    chk("R7 irq disabled", int'(irq), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule